// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block forms one dispatch group per clock from a short, program-ordered window of decoded instructions. Every window entry carries a valid bit and a class code. The allocator walks the window from its oldest entry and places each instruction in a five-slot group. Slots 1 to 4 hold ordinary internal ops. Slot 5 is reserved for a branch. The allocator stops at the first instruction that cannot be placed, and that instruction waits for the next group.

Slot position fixes the execution-unit copy and the issue timing. The first two slots issue at once. Slots 3 and 4 issue one cycle later. An integer divide is always forced onto the second unit copy. The number of instructions taken is reported combinationally, in the same cycle, so the upstream window can shift. The group itself is registered and appears after the next clock edge. A downstream stall freezes the registered group and stops all consumption.

Top module: `dispatch_slot_alloc`

## Requirements
- R1: While `rst_n` is low at a clock edge, all slot valid bits become 0 after that edge.
- R2: Instructions are placed strictly in window order, starting from window entry 0. Packing stops at the first entry whose valid bit is 0. A later instruction never occupies a lower non-branch slot than an earlier one.
- R3: Class code 0 (simple, and also the unused codes 6 and 7) takes the lowest free slot among slots 1 to 4. If slots 1 to 4 are all used, the group closes.
- R4: Class code 1 (cracked) takes two adjacent slots, either 1+2, 2+3 or 3+4, starting at the lowest free slot. If no such pair is free, the group closes.
- R5: Class code 2 (whole-group) is placed only into an empty group. It fills slots 1 to 4, all reporting the same index, and closes the group.
- R6: Class code 3 (first-slot-only) is placed only into an empty group, where it takes slot 1.
- R7: Class code 5 (divide) is placed only into an empty group, where it takes slots 1 and 2. Both slots select unit copy 2 (unit bit 1).
- R8: Class code 4 (branch) takes slot 5 whenever the group is still open, and closes the group. Any unfilled slots among 1 to 4 stay empty.
- R9: Steering by slot, written as unit bit / late bit, where unit bit 0 means copy 1:
  - slot 1: 0/0
  - slot 2: 1/0
  - slot 3: 1/1
  - slot 4: 0/1
  - slot 5: 0/0
  The divide rule of R7 overrides the unit bit.
- R10: `consumed_o` equals the number of window entries placed, in the same cycle as the window is presented. The matching slot outputs appear after the next rising clock edge. Slot bit k of each per-slot bus is slot k+1, and a slot index field is `slot_idx_o[k*IDXW +: IDXW]`.
- R11: While `stall_i` is high, `consumed_o` is 0 and the slot outputs keep their values across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Downstream hold of the current group |
| win_vld_i | input | WIN | Valid bit per window entry, entry 0 oldest |
| win_cls_i | input | 3*WIN | Class code per entry, entry i at [3*i +: 3] |
| consumed_o | output | $clog2(WIN+1) | Entries taken this cycle |
| slot_vld_o | output | 5 | Slot holds an op |
| slot_idx_o | output | 5*IDXW | Window index of the op in each slot |
| slot_unit_o | output | 5 | Unit copy select per slot (0 = copy 1) |
| slot_late_o | output | 5 | Issue one cycle later |

## Verification
The stall hold and the packing of a new window can fall in the same cycle. In that case the registered group must stay frozen, and the count must read zero, even though the window now holds a different class mix. The bench sets up a known group, then raises the stall together with a whole-group window. It judges `consumed_o` before the edge and all slot buses after it against the earlier group, and then checks that the new window is packed once the stall drops. A second overlap, a branch closing a group that a cracked op could not complete, is covered by the exhaustive sweep over class codes in the first four entries.

// File: rtl/dsa_pkg.sv
// Package: shared constants and class codes for the dispatch slot allocator.
// Assumes a fixed five-slot group whose last slot is reserved for branches.
package dsa_pkg;
    localparam int NSLOT = 5;
    localparam int NBODY = 4;
    localparam int CLSW  = 3;

    typedef enum logic [CLSW-1:0] {
        CL_SIMPLE = 3'd0,
        CL_CRACK  = 3'd1,
        CL_WHOLE  = 3'd2,
        CL_FIRST  = 3'd3,
        CL_BRANCH = 3'd4,
        CL_DIVIDE = 3'd5
    } cls_e;
endpackage

// File: rtl/dsa_packer.sv
// Module: dsa_packer
// Walks the instruction window in order and places each entry into the
// group slots by class. It stops at the first invalid entry or the first
// entry that does not fit. Purely combinational.
// Assumes the window entries are in program order, with entry 0 the oldest.
module dsa_packer
    import dsa_pkg::*;
#(
    parameter int WIN  = 5,
    parameter int IDXW = 3,
    parameter int CNTW = 3
) (
    input  logic [WIN-1:0]        win_vld,
    input  logic [CLSW*WIN-1:0]   win_cls,
    output logic [CNTW-1:0]       take_cnt,
    output logic [NSLOT-1:0]      grp_vld,
    output logic [NSLOT*IDXW-1:0] grp_idx,
    output logic [NSLOT-1:0]      grp_force
);
    // Sequential placement of window entries into slots.
    always_comb begin
        logic [2:0]      pos;
        logic            done;
        logic [CNTW-1:0] cnt;
        cls_e            cls;
        pos       = 3'd0;
        done      = 1'b0;
        cnt       = '0;
        cls       = CL_SIMPLE;
        grp_vld   = '0;
        grp_idx   = '0;
        grp_force = '0;
        for (int i = 0; i < WIN; i++) begin
            if (!done) begin
                if (!win_vld[i]) begin
                    done = 1'b1;
                end else begin
                    cls = cls_e'(win_cls[i*CLSW +: CLSW]);
                    case (cls)
                        CL_BRANCH: begin
                            grp_vld[NSLOT-1] = 1'b1;
                            grp_idx[(NSLOT-1)*IDXW +: IDXW] = IDXW'(i);
                            cnt  = cnt + 1'b1;
                            done = 1'b1;
                        end
                        CL_CRACK: begin
                            if (pos <= 3'd2) begin
                                grp_vld[pos]      = 1'b1;
                                grp_vld[pos+3'd1] = 1'b1;
                                grp_idx[pos*IDXW +: IDXW]        = IDXW'(i);
                                grp_idx[(pos+3'd1)*IDXW +: IDXW] = IDXW'(i);
                                pos = pos + 3'd2;
                                cnt = cnt + 1'b1;
                            end else begin
                                done = 1'b1;
                            end
                        end
                        CL_WHOLE: begin
                            if (pos == 3'd0) begin
                                for (int s = 0; s < NBODY; s++) begin
                                    grp_vld[s] = 1'b1;
                                    grp_idx[s*IDXW +: IDXW] = IDXW'(i);
                                end
                                cnt = cnt + 1'b1;
                            end
                            done = 1'b1;
                        end
                        CL_FIRST: begin
                            if (pos == 3'd0) begin
                                grp_vld[0] = 1'b1;
                                grp_idx[0 +: IDXW] = IDXW'(i);
                                pos = 3'd1;
                                cnt = cnt + 1'b1;
                            end else begin
                                done = 1'b1;
                            end
                        end
                        CL_DIVIDE: begin
                            if (pos == 3'd0) begin
                                grp_vld[1:0]   = 2'b11;
                                grp_force[1:0] = 2'b11;
                                grp_idx[0 +: IDXW]    = IDXW'(i);
                                grp_idx[IDXW +: IDXW] = IDXW'(i);
                                pos = 3'd2;
                                cnt = cnt + 1'b1;
                            end else begin
                                done = 1'b1;
                            end
                        end
                        default: begin
                            if (pos < 3'(NBODY)) begin
                                grp_vld[pos] = 1'b1;
                                grp_idx[pos*IDXW +: IDXW] = IDXW'(i);
                                pos = pos + 3'd1;
                                cnt = cnt + 1'b1;
                            end else begin
                                done = 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
        take_cnt = cnt;
    end
endmodule

// File: rtl/dsa_steer.sv
// Module: dsa_steer
// Maps one slot position to its unit-copy select and late-issue flag.
// Assumes SLOT is 0-based. force_hi overrides the unit select to copy 2.
module dsa_steer #(
    parameter int SLOT = 0
) (
    input  logic force_hi,
    output logic unit,
    output logic late
);
    localparam logic UNIT_HI = (SLOT == 1) || (SLOT == 2);
    localparam logic LATE    = (SLOT == 2) || (SLOT == 3);

    // Fixed steering by position, with the divide override.
    always_comb begin
        unit = UNIT_HI | force_hi;
        late = LATE;
    end
endmodule

// File: rtl/dsa_hold_reg.sv
// Module: dsa_hold_reg
// Register that loads when hold is low and keeps its value otherwise.
// Assumes a synchronous active-low reset that clears it to zero.
module dsa_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture when not held.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (!hold) q <= d;
    end
endmodule

// File: rtl/dispatch_slot_alloc.sv
// Module: dispatch_slot_alloc (top)
// Packs an in-order instruction window into a registered five-slot group.
// The taken count is combinational. The group appears after the clock edge.
// Assumes the upstream drops consumed_o entries from the window head
// at each edge.
module dispatch_slot_alloc
    import dsa_pkg::*;
#(
    parameter int WIN = 5
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      stall_i,
    input  logic [WIN-1:0]                            win_vld_i,
    input  logic [3*WIN-1:0]                          win_cls_i,
    output logic [$clog2(WIN+1)-1:0]                  consumed_o,
    output logic [4:0]                                slot_vld_o,
    output logic [5*((WIN > 1) ? $clog2(WIN) : 1)-1:0] slot_idx_o,
    output logic [4:0]                                slot_unit_o,
    output logic [4:0]                                slot_late_o
);
    localparam int IDXW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int CNTW = $clog2(WIN + 1);
    localparam int RW   = NSLOT * (IDXW + 3);

    logic [CNTW-1:0]       take_cnt;
    logic [NSLOT-1:0]      grp_vld;
    logic [NSLOT*IDXW-1:0] grp_idx;
    logic [NSLOT-1:0]      grp_force;
    logic [NSLOT-1:0]      grp_unit;
    logic [NSLOT-1:0]      grp_late;
    logic [RW-1:0]         grp_d;
    logic [RW-1:0]         grp_q;

    dsa_packer #(.WIN(WIN), .IDXW(IDXW), .CNTW(CNTW)) u_packer (
        .win_vld   (win_vld_i),
        .win_cls   (win_cls_i),
        .take_cnt  (take_cnt),
        .grp_vld   (grp_vld),
        .grp_idx   (grp_idx),
        .grp_force (grp_force)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_steer
        dsa_steer #(.SLOT(s)) u_steer (
            .force_hi (grp_force[s]),
            .unit     (grp_unit[s]),
            .late     (grp_late[s])
        );
    end

    // Assemble the group word for the output register.
    always_comb grp_d = {grp_vld, grp_idx, grp_unit, grp_late};

    dsa_hold_reg #(.W(RW)) u_grp_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (stall_i),
        .d     (grp_d),
        .q     (grp_q)
    );

    // Split the registered group and gate the count with the stall.
    always_comb begin
        {slot_vld_o, slot_idx_o, slot_unit_o, slot_late_o} = grp_q;
        consumed_o = stall_i ? '0 : take_cnt;
    end
endmodule

// File: rtl/dispatch_slot_alloc_chk.sv
// Module: dispatch_slot_alloc_chk
// Temporal checks on the allocator ports, attached by bind.
module dispatch_slot_alloc_chk #(
    parameter int WIN = 5
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      stall_i,
    input logic [WIN-1:0]                            win_vld_i,
    input logic [3*WIN-1:0]                          win_cls_i,
    input logic [$clog2(WIN+1)-1:0]                  consumed_o,
    input logic [4:0]                                slot_vld_o,
    input logic [5*((WIN > 1) ? $clog2(WIN) : 1)-1:0] slot_idx_o,
    input logic [4:0]                                slot_unit_o,
    input logic [4:0]                                slot_late_o
);
    localparam int IDXW = (WIN > 1) ? $clog2(WIN) : 1;

    a_r11_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> consumed_o == '0);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(slot_vld_o) && $stable(slot_idx_o)
                     && $stable(slot_unit_o) && $stable(slot_late_o)));

    a_r10_first_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && win_vld_i[0]) |=> slot_vld_o != 5'd0);

    a_r10_empty_group: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && consumed_o == '0) |=> slot_vld_o == 5'd0);

    for (genvar j = 0; j < 3; j++) begin : g_ord
        a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_vld_o[j] && slot_vld_o[j+1])
                |-> slot_idx_o[j*IDXW +: IDXW] <= slot_idx_o[(j+1)*IDXW +: IDXW]);
    end
endmodule

bind dispatch_slot_alloc dispatch_slot_alloc_chk #(.WIN(WIN)) u_chk (.*);

// File: tb/test_dispatch_slot_alloc.sv
// Bench: exhaustive class sweep over the first four window entries,
// a valid-mask sweep, plus reset and stall directed cases.
module test_dispatch_slot_alloc;
    localparam int WIN  = 5;
    localparam int IDXW = 3;
    localparam int CNTW = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 stall_i = 1'b0;
    logic [WIN-1:0]       win_vld_i = '0;
    logic [3*WIN-1:0]     win_cls_i = '0;
    logic [CNTW-1:0]      consumed_o;
    logic [4:0]           slot_vld_o;
    logic [5*IDXW-1:0]    slot_idx_o;
    logic [4:0]           slot_unit_o;
    logic [4:0]           slot_late_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    int e_cnt;
    bit e_v[5];
    int e_idx[5];
    bit e_f[5];

    always #10 clk = ~clk;

    dispatch_slot_alloc #(.WIN(WIN)) i_dispatch_slot_alloc (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected group from the class rules of R2 to R8.
    task automatic model(input logic [WIN-1:0] v, input logic [3*WIN-1:0] c);
        int pos = 0;
        bit done = 0;
        e_cnt = 0;
        for (int s = 0; s < 5; s++) begin e_v[s] = 0; e_idx[s] = 0; e_f[s] = 0; end
        for (int i = 0; i < WIN; i++) begin
            int k = int'(c[i*3 +: 3]);
            if (done) continue;
            if (!v[i]) begin done = 1; continue; end
            if (k == 4) begin
                e_v[4] = 1; e_idx[4] = i; e_cnt++; done = 1;
            end else if (k == 1) begin
                if (pos < 3) begin
                    e_v[pos] = 1; e_v[pos+1] = 1; e_idx[pos] = i; e_idx[pos+1] = i;
                    pos += 2; e_cnt++;
                end else done = 1;
            end else if (k == 2) begin
                if (pos == 0) begin
                    for (int s = 0; s < 4; s++) begin e_v[s] = 1; e_idx[s] = i; end
                    e_cnt++;
                end
                done = 1;
            end else if (k == 3) begin
                if (pos == 0) begin e_v[0] = 1; e_idx[0] = i; pos = 1; e_cnt++; end
                else done = 1;
            end else if (k == 5) begin
                if (pos == 0) begin
                    e_v[0] = 1; e_v[1] = 1; e_idx[0] = i; e_idx[1] = i;
                    e_f[0] = 1; e_f[1] = 1; pos = 2; e_cnt++;
                end else done = 1;
            end else begin
                if (pos < 4) begin e_v[pos] = 1; e_idx[pos] = i; pos++; e_cnt++; end
                else done = 1;
            end
        end
    endtask

    // Compare registered slots to the model (R2..R9).
    task automatic check_slots(input string tag);
        for (int s = 0; s < 5; s++) begin
            bit xu = e_f[s] | (s == 1) | (s == 2);
            bit xl = (s == 2) | (s == 3);
            chk(slot_vld_o[s] == e_v[s], {tag, " R2 R3 R4 R5 R6 R7 R8 slot valid"},
                slot_vld_o[s], e_v[s]);
            if (e_v[s]) begin
                chk(int'(slot_idx_o[s*IDXW +: IDXW]) == e_idx[s], {tag, " R2 slot index"},
                    slot_idx_o[s*IDXW +: IDXW], e_idx[s]);
                chk(slot_unit_o[s] == xu, {tag, " R9 R7 unit select"}, slot_unit_o[s], xu);
                chk(slot_late_o[s] == xl, {tag, " R9 late flag"}, slot_late_o[s], xl);
            end
        end
    endtask

    // Present a window, check the count before the edge, the slots after it.
    task automatic apply(input logic [WIN-1:0] v, input logic [3*WIN-1:0] c, input string tag);
        @(negedge clk);
        win_vld_i = v;
        win_cls_i = c;
        model(v, c);
        #1;
        chk(int'(consumed_o) == e_cnt, {tag, " R10 consumed count"}, consumed_o, e_cnt);
        @(posedge clk);
        #1;
        check_slots(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [3*WIN-1:0] held_cls;
        // R1: reset clears the group even with a valid window present.
        win_vld_i = '1;
        repeat (2) @(posedge clk);
        #1;
        chk(slot_vld_o == 5'd0, "R1 reset slot valid", slot_vld_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2..R10: all class codes across the first four entries.
        for (int a = 0; a < 6; a++)
            for (int b = 0; b < 6; b++)
                for (int c = 0; c < 6; c++)
                    for (int d = 0; d < 6; d++)
                        apply(5'b11111, {3'd0, 3'(d), 3'(c), 3'(b), 3'(a)}, "sweep");

        // R2: valid masks with simple ops, and unused codes 6/7 as simple (R3).
        for (int m = 0; m < 32; m++) apply(5'(m), {3'd0, 3'd7, 3'd6, 3'd0, 3'd0}, "mask");

        // R11: stall while a different window is presented.
        apply(5'b00011, {3'd0, 3'd0, 3'd0, 3'd0, 3'd1}, "pre-stall");
        held_cls = {3'd0, 3'd0, 3'd0, 3'd0, 3'd1};
        @(negedge clk);
        stall_i   = 1'b1;
        win_vld_i = 5'b00001;
        win_cls_i = {3'd0, 3'd0, 3'd0, 3'd0, 3'd2};
        #1;
        chk(consumed_o == '0, "R11 consumed under stall", consumed_o, 0);
        repeat (2) @(posedge clk);
        #1;
        model(5'b00011, held_cls);
        check_slots("R11 held");
        @(negedge clk);
        stall_i = 1'b0;
        apply(5'b00001, {3'd0, 3'd0, 3'd0, 3'd0, 3'd2}, "R11 release R5");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule